// File: doc/BRIEF.md
# Third-Order Cascaded Fractional Ratio Modulator

This block sets the instantaneous division ratio of a fractional-N synthesizer. A 15-bit fractional word is added every cycle into the first of three cascaded first-order accumulators. Each later accumulator adds in the residue that the stage before it produced in the same cycle. The three carry bits pass through a noise-cancelling network of first and second differences, which gives a small signed offset dN with third-order shaped quantisation noise. Over time the offset averages to the fractional word divided by 2^15.

The offset is added to a 7-bit base ratio. The sum is limited to the range the multi-modulus divider accepts, 64 to 127, and both values are registered. The block runs on the divided output clock, so each division period gets exactly one new ratio. The step size is the reference frequency over 2^15, which is about 610 Hz at a 20 MHz reference.

Top module: `mash3_frac_mod`

## Requirements
- R1: Starting from reset, the sum of `ofs_o` over the first 2^15 edges equals `frac_i` within plus or minus 2. `frac_i` is held constant for this, and each accumulator wraps modulo 2^15.
- R2: The offset is the stage-1 carry, plus the first difference of the stage-2 carry, plus the second difference of the stage-3 carry. With `frac_i` = 16384 held from reset, `ofs_o` repeats 0, +2, -1, +1 from the first edge after reset.
- R3: `ofs_o` is a 4-bit two's complement value that always lies between -3 and +4.
- R4: While `frac_i` has been 0 at every edge since reset, `ofs_o` is 0 and `ratio_o` equals the limited base.
- R5: At every rising edge of `clk_div_i` out of reset, `ratio_o` and `ofs_o` take the values for that edge. `ratio_o` is `base_i` + `ofs_o` whenever that sum lies in 64..127.
- R6: `ratio_o` is 7-bit unsigned and never leaves 64..127. A sum above 127 gives 127, and a sum below 64 gives 64.
- R7: Reset is synchronous and active low. Reset clears all three accumulators and the stored carries, and sets `ratio_o` to 64 and `ofs_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_div_i | input | 1 | Divided output clock; one update per edge |
| rst_n_i | input | 1 | Synchronous active-low reset |
| frac_i | input | 15 | Fractional word, step of 1/2^15 |
| base_i | input | 7 | Integer base ratio |
| ratio_o | output | 7 | Registered, limited ratio for the divider |
| ofs_o | output | 4 | Registered signed offset dN |

## Verification
Both outputs are registered once. The value for edge k therefore appears just after that edge, and the bench samples it on the following falling edge. Deterministic sequences and the pass-through relation are checked at that point, cycle by cycle, counting from the first edge after reset is released. The long-run average is checked with a tally of 2^15 consecutive offsets, each taken on a falling edge. Reset values are read on a falling edge while reset is still held.

// File: rtl/mash_pkg.sv
// Shared constants for the cascaded fractional modulator.
// Assumes: exactly three cascaded stages; the cancel network is written for three.
package mash_pkg;
    localparam int ACC_W_DEF   = 15;  // accumulator width
    localparam int RATIO_W_DEF = 7;   // divider word width
    localparam int OFS_W_DEF   = 4;   // signed offset width (-8..7 holds -3..+4)
    localparam int RATIO_MIN_DEF = 64;
    localparam int RATIO_MAX_DEF = 127;
    localparam int NSTG        = 3;   // cascade order
endpackage

// File: rtl/mash_acc_chain.sv
// Three cascaded first-order accumulators.
// Stage 0 adds the fractional word; stage g adds stage g-1's new residue in the
// same cycle. Carries are combinational from the current state and inputs.
// Assumes: synchronous active-low reset, one update per divided clock.
module mash_acc_chain
    import mash_pkg::*;
#(
    parameter int ACC_W = ACC_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [ACC_W-1:0] frac_i,
    output logic [NSTG-1:0]  carry_o
);
    logic [ACC_W-1:0] acc_q [NSTG];
    logic [ACC_W:0]   sum   [NSTG];

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        // Purpose: add this stage's input into its residue, one bit wider for the carry.
        if (g == 0) begin : g_first
            assign sum[g] = {1'b0, acc_q[g]} + {1'b0, frac_i};
        end else begin : g_next
            assign sum[g] = {1'b0, acc_q[g]} + {1'b0, sum[g-1][ACC_W-1:0]};
        end

        assign carry_o[g] = sum[g][ACC_W];

        // Purpose: keep the residue modulo 2^ACC_W.
        always_ff @(posedge clk_i) begin
            if (!rst_n_i) acc_q[g] <= '0;
            else          acc_q[g] <= sum[g][ACC_W-1:0];
        end
    end
endmodule

// File: rtl/mash_cancel.sv
// Noise-cancelling combiner: dN = c1 + (1-z^-1)c2 + (1-z^-1)^2 c3.
// Keeps one old copy of c2 and two old copies of c3.
// Assumes: carry_i[0] is the first stage; the result spans -3..+4.
module mash_cancel
    import mash_pkg::*;
#(
    parameter int OFS_W = OFS_W_DEF
) (
    input  logic                    clk_i,
    input  logic                    rst_n_i,
    input  logic [NSTG-1:0]         carry_i,
    output logic signed [OFS_W-1:0] ofs_o
);
    logic c2_d, c3_d, c3_dd;
    logic signed [OFS_W-1:0] t1, t2, t2d, t3, t3d, t3dd;

    // Purpose: delay line for the differenced carries.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            c2_d  <= 1'b0;
            c3_d  <= 1'b0;
            c3_dd <= 1'b0;
        end else begin
            c2_d  <= carry_i[1];
            c3_d  <= carry_i[2];
            c3_dd <= c3_d;
        end
    end

    // Purpose: widen the single-bit terms and sum them as signed values.
    always_comb begin
        t1    = OFS_W'(carry_i[0]);
        t2    = OFS_W'(carry_i[1]);
        t2d   = OFS_W'(c2_d);
        t3    = OFS_W'(carry_i[2]);
        t3d   = OFS_W'(c3_d);
        t3dd  = OFS_W'(c3_dd);
        ofs_o = t1 + (t2 - t2d) + (t3 - (t3d <<< 1) + t3dd);
    end
endmodule

// File: rtl/mash_ratio_out.sv
// Adds the signed offset to the base ratio, limits it to the divider's range,
// and registers both the ratio and the offset.
// Assumes: RATIO_MIN <= RATIO_MAX < 2^RATIO_W.
module mash_ratio_out #(
    parameter int RATIO_W   = 7,
    parameter int OFS_W     = 4,
    parameter int RATIO_MIN = 64,
    parameter int RATIO_MAX = 127
) (
    input  logic                      clk_i,
    input  logic                      rst_n_i,
    input  logic [RATIO_W-1:0]        base_i,
    input  logic signed [OFS_W-1:0]   ofs_i,
    output logic [RATIO_W-1:0]        ratio_o,
    output logic signed [OFS_W-1:0]   ofs_o
);
    localparam int SUM_W = RATIO_W + 2;
    localparam logic signed [SUM_W-1:0] LO = SUM_W'(RATIO_MIN);
    localparam logic signed [SUM_W-1:0] HI = SUM_W'(RATIO_MAX);

    logic signed [SUM_W-1:0] sum;
    logic [RATIO_W-1:0]      lim;

    // Purpose: signed sum of base and offset, then limit to the legal window.
    always_comb begin
        sum = $signed(SUM_W'(base_i)) + SUM_W'(ofs_i);
        if (sum < LO)      lim = RATIO_W'(RATIO_MIN);
        else if (sum > HI) lim = RATIO_W'(RATIO_MAX);
        else               lim = sum[RATIO_W-1:0];
    end

    // Purpose: present one ratio per divided clock edge.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            ratio_o <= RATIO_W'(RATIO_MIN);
            ofs_o   <= '0;
        end else begin
            ratio_o <= lim;
            ofs_o   <= ofs_i;
        end
    end
endmodule

// File: rtl/mash3_frac_mod.sv
// Top of the third-order cascaded fractional ratio modulator.
// Runs on the divided clock; outputs are registered, one edge after the state they reflect.
// Assumes: frac_i and base_i are stable around each rising edge.
module mash3_frac_mod
    import mash_pkg::*;
#(
    parameter int ACC_W     = ACC_W_DEF,
    parameter int RATIO_W   = RATIO_W_DEF,
    parameter int OFS_W     = OFS_W_DEF,
    parameter int RATIO_MIN = RATIO_MIN_DEF,
    parameter int RATIO_MAX = RATIO_MAX_DEF
) (
    input  logic                    clk_div_i,
    input  logic                    rst_n_i,
    input  logic [ACC_W-1:0]        frac_i,
    input  logic [RATIO_W-1:0]      base_i,
    output logic [RATIO_W-1:0]      ratio_o,
    output logic signed [OFS_W-1:0] ofs_o
);
    logic [NSTG-1:0]         carry;
    logic signed [OFS_W-1:0] dn_comb;

    mash_acc_chain #(.ACC_W(ACC_W)) u_chain (
        .clk_i   (clk_div_i),
        .rst_n_i (rst_n_i),
        .frac_i  (frac_i),
        .carry_o (carry)
    );

    mash_cancel #(.OFS_W(OFS_W)) u_cancel (
        .clk_i   (clk_div_i),
        .rst_n_i (rst_n_i),
        .carry_i (carry),
        .ofs_o   (dn_comb)
    );

    mash_ratio_out #(
        .RATIO_W(RATIO_W), .OFS_W(OFS_W),
        .RATIO_MIN(RATIO_MIN), .RATIO_MAX(RATIO_MAX)
    ) u_out (
        .clk_i   (clk_div_i),
        .rst_n_i (rst_n_i),
        .base_i  (base_i),
        .ofs_i   (dn_comb),
        .ratio_o (ratio_o),
        .ofs_o   (ofs_o)
    );
endmodule

// File: rtl/mash3_frac_chk.sv
// Property checker for mash3_frac_mod, attached by bind below.
module mash3_frac_chk #(
    parameter int ACC_W     = 15,
    parameter int RATIO_W   = 7,
    parameter int OFS_W     = 4,
    parameter int RATIO_MIN = 64,
    parameter int RATIO_MAX = 127
) (
    input logic                    clk_i,
    input logic                    rst_n_i,
    input logic [ACC_W-1:0]        frac_i,
    input logic [RATIO_W-1:0]      base_i,
    input logic [RATIO_W-1:0]      ratio_o,
    input logic signed [OFS_W-1:0] ofs_o,
    input logic signed [OFS_W-1:0] core_ofs_i
);
    logic zero_run;
    int   raw_sum;

    // Purpose: remember whether every fractional word since reset was zero.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) zero_run <= 1'b1;
        else          zero_run <= zero_run && (frac_i == '0);
    end

    assign raw_sum = int'(base_i) + int'(core_ofs_i);

    AST_OFS_SPAN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (int'(core_ofs_i) >= -3 && int'(core_ofs_i) <= 4)); // R3

    AST_RATIO_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (int'(ratio_o) >= RATIO_MIN && int'(ratio_o) <= RATIO_MAX)); // R6

    AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (raw_sum >= RATIO_MIN && raw_sum <= RATIO_MAX)
        |=> (int'(ratio_o) == $past(raw_sum)) && (ofs_o == $past(core_ofs_i))); // R5

    AST_ZERO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (zero_run && frac_i == '0) |=> (ofs_o == '0)); // R4

    AST_RESET_STATE: assert property (@(posedge clk_i)
        !rst_n_i |=> (int'(ratio_o) == RATIO_MIN && ofs_o == '0)); // R7
endmodule

bind mash3_frac_mod mash3_frac_chk #(
    .ACC_W(ACC_W), .RATIO_W(RATIO_W), .OFS_W(OFS_W),
    .RATIO_MIN(RATIO_MIN), .RATIO_MAX(RATIO_MAX)
) u_chk (
    .clk_i      (clk_div_i),
    .rst_n_i    (rst_n_i),
    .frac_i     (frac_i),
    .base_i     (base_i),
    .ratio_o    (ratio_o),
    .ofs_o      (ofs_o),
    .core_ofs_i (dn_comb)
);

// File: tb/test_mash3_frac_mod.sv
module test_mash3_frac_mod;
    localparam int CLK_PER = 10;
    localparam int LONG_N  = 32768;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [14:0]       frac = '0;
    logic [6:0]        base = 7'd100;
    logic [6:0]        ratio;
    logic signed [3:0] ofs;

    int total = 0;
    int bad   = 0;

    // Long-average vectors: {frac, base}; expected sum is computed from frac.
    localparam logic [21:0] VECS [4] = '{
        {15'd1,     7'd80},
        {15'd12345, 7'd90},
        {15'd32767, 7'd76},
        {15'd20000, 7'd127}
    };
    localparam int HALF_SEQ [4] = '{0, 2, -1, 1};

    always #(CLK_PER/2) clk = ~clk;

    mash3_frac_mod i_mash3_frac_mod (
        .clk_div_i (clk),
        .rst_n_i   (rst_n),
        .frac_i    (frac),
        .base_i    (base),
        .ratio_o   (ratio),
        .ofs_o     (ofs)
    );

    function automatic int lim(input int v);
        if (v < 64)  return 64;
        if (v > 127) return 127;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Hold reset over two edges with the given inputs, check reset state, release.
    task automatic do_reset(input logic [14:0] f, input logic [6:0] b);
        @(negedge clk);
        rst_n = 1'b0;
        frac  = f;
        base  = b;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(ratio == 7'd64, "R7 ratio", int'(ratio), 64);
        chk(ofs == 4'sd0, "R7 ofs", int'(ofs), 0);
        rst_n = 1'b1;
    endtask

    // Run n edges against the repeating half-step sequence.
    task automatic half_seq(input logic [6:0] b, input int n, input string req);
        do_reset(15'd16384, b);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk(int'(ofs) == HALF_SEQ[i % 4], {req, " ofs"}, int'(ofs), HALF_SEQ[i % 4]);
            chk(int'(ratio) == lim(int'(b) + HALF_SEQ[i % 4]), {req, " ratio"},
                int'(ratio), lim(int'(b) + HALF_SEQ[i % 4]));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // Table walk: long-run average, range and ratio relation (R1, R3, R5, R6).
        for (int v = 0; v < 4; v++) begin
            logic [14:0] f;
            logic [6:0]  b;
            int          acc;
            int          span_bad;
            int          rel_bad;
            f = VECS[v][21:7];
            b = VECS[v][6:0];
            acc = 0;
            span_bad = 0;
            rel_bad = 0;
            do_reset(f, b);
            for (int i = 0; i < LONG_N; i++) begin
                @(posedge clk);
                @(negedge clk);
                acc += int'(ofs);
                if (int'(ofs) < -3 || int'(ofs) > 4) span_bad++;
                if (int'(ratio) != lim(int'(b) + int'(ofs))) rel_bad++;
            end
            chk(acc >= int'(f) - 2 && acc <= int'(f) + 2, "R1 average", acc, int'(f));
            chk(span_bad == 0, "R3 span", span_bad, 0);
            chk(rel_bad == 0, "R5 R6 ratio", rel_bad, 0);
        end

        // R2: deterministic period-4 sequence after a reset that clears prior state.
        half_seq(7'd100, 8, "R2");

        // R6: limit at the top, at the bottom, and for a base below the window.
        half_seq(7'd127, 4, "R6 top");
        half_seq(7'd64, 4, "R6 bottom");
        half_seq(7'd5, 4, "R6 low base");

        // R4: zero fractional word from reset leaves the base untouched.
        do_reset(15'd0, 7'd90);
        for (int i = 0; i < 20; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk(ofs == 4'sd0, "R4 ofs", int'(ofs), 0);
            chk(ratio == 7'd90, "R4 ratio", int'(ratio), 90);
        end

        // R5: a base change shows on the very next edge's output.
        @(negedge clk);
        base = 7'd111;
        @(posedge clk);
        @(negedge clk);
        chk(ratio == 7'd111, "R5 base step", int'(ratio), 111);

        // R7: reset mid-run forces the reset state again.
        do_reset(15'd16384, 7'd100);
        @(posedge clk);
        @(negedge clk);
        chk(int'(ofs) == 0, "R7 restart", int'(ofs), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule